// File: doc/BRIEF.md
# Tree Serializer with Selectable Bit Order

This block converts parallel words into a single serial bit stream that runs at the full bit clock, so each word takes 2^LEVELS clock cycles to leave (16 with the default LEVELS of 4). The divider that produces the half, quarter, eighth and sixteenth rate clocks sits outside the block. Its outputs arrive as level inputs and are sampled in the full-rate domain. The slowest of them marks word boundaries. The next-slower ones steer a binary tree of 2:1 selectors, which picks one bit of the captured word in each cycle.

A word is taken in once per word period, on the falling edge of the slowest divided clock. A static order input, sampled together with the word, chooses whether the lowest or the highest input bit leaves first. One word period of latency separates presenting a word from its bits appearing on the serial output. A forwarded copy of the full-rate clock goes out beside the data, and a disable input can gate it off.

Top module: `tree_ser16`

## Requirements
- R1: While reset is held, and after reset until the first captured word reaches the output, ser_o is 0.
- R2: A word is captured only at a rising clk edge where div_clk_i[LEVELS-1] is 0 and was 1 at the previous rising edge, which is the falling edge of the slowest divided clock.
- R3: With high_first_i at 0 when a word is captured, the word leaves lowest bit first: par_word_i[0], then [1], and so on up to [15].
- R4: With high_first_i at 1 when a word is captured, the word leaves highest bit first: par_word_i[15], then [14], and so on down to [0].
- R5: ser_o carries one bit per clk cycle. Words captured at successive boundaries follow each other with no gap and no repeated bit.
- R6: The first bit of a word captured at rising edge E appears on ser_o after edge E+1, and its last bit after edge E+16. The bit index that the tree selects equals the value of div_clk_i (read as a binary number) at the previous rising edge.
- R7: high_first_i has no effect except at a capture edge. Toggling it mid-word changes neither the word being sent nor the order of the next word.
- R8: Changes of par_word_i between capture edges have no effect on ser_o.
- R9: fclk_o follows clk while fwd_off_i is 0, and is held at 0 while fwd_off_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| par_word_i | input | 16 | Parallel word to serialize |
| high_first_i | input | 1 | 0: bit 0 first; 1: bit 15 first |
| div_clk_i | input | 4 | Divided clocks from the external divider; bit k runs at clk/2^(k+1) |
| fwd_off_i | input | 1 | 1 gates the forwarded clock off |
| ser_o | output | 1 | Serial data stream |
| fclk_o | output | 1 | Forwarded full-rate clock |

## Verification
Single-bit words (0x0001 and 0x8000) are sent in both orders. A design that swapped the orders, or that was off by one in the bit index it derives from the divided clocks, would place the lone 1 in the wrong slot. Some words have both the data and the order input disturbed in the middle of the period and then restored before capture. A design that sampled either input continuously would corrupt the word in flight or the next word. The first word after reset is checked against the all-zero output that comes before it, which exposes early capture or wrong reset values. The forwarded clock is checked in both its high and low phases with the gate on and off.

// File: rtl/ser_pkg.sv
package ser_pkg;

  // Which end of the parallel word is serialized first.
  typedef enum logic {
    ORD_LOW_FIRST  = 1'b0,
    ORD_HIGH_FIRST = 1'b1
  } ser_order_e;

endpackage

// File: rtl/ser_rst_sync.sv
module ser_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/ser_phase_track.sv
// Retimes the divided clock levels into the full-rate domain. The registered
// copy drives the tree selects, and the top bit marks word boundaries.
module ser_phase_track #(
  parameter int LEVELS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] div_i,
  output logic [LEVELS-1:0] sel_o,
  output logic              bound_o
);

  logic [LEVELS-1:0] ph_q;
  logic [LEVELS-1:0] ph_d;

  always_comb begin
    ph_d = div_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign sel_o   = ph_q;
  // Falling edge of the slowest divided clock.
  assign bound_o = ph_q[LEVELS-1] & ~div_i[LEVELS-1];

endmodule

// File: rtl/ser_word_cap.sv
// Captures one word per boundary and applies the bit order at capture time.
module ser_word_cap
  import ser_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  ser_order_e       order_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] word_o
);

  logic [WIDTH-1:0] rev_w;
  logic [WIDTH-1:0] cap_q;
  logic [WIDTH-1:0] cap_d;

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign rev_w[i] = word_i[WIDTH-1-i];
  end

  always_comb begin
    cap_d = cap_q;
    if (load_i) begin
      cap_d = (order_i == ORD_HIGH_FIRST) ? rev_w : word_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else begin
      cap_q <= cap_d;
    end
  end

  assign word_o = cap_q;

endmodule

// File: rtl/ser_mux_tree.sv
// Binary tree of 2:1 selectors held in heap order. Node 1 is the root and
// leaves sit at WIDTH+i. A node at depth d is steered by sel_i[LEVELS-1-d],
// so the deepest level uses the fastest divided clock.
module ser_mux_tree #(
  parameter int LEVELS = 4
) (
  input  logic [(1<<LEVELS)-1:0] word_i,
  input  logic [LEVELS-1:0]      sel_i,
  output logic                   bit_o
);

  localparam int WIDTH = 1 << LEVELS;

  logic [2*WIDTH-1:1] node;

  for (genvar i = 0; i < WIDTH; i++) begin : g_leaf
    assign node[WIDTH+i] = word_i[i];
  end

  for (genvar k = 1; k < WIDTH; k++) begin : g_node
    localparam int DEPTH = $clog2(k + 1) - 1;
    assign node[k] = sel_i[LEVELS-1-DEPTH] ? node[2*k+1] : node[2*k];
  end

  assign bit_o = node[1];

endmodule

// File: rtl/tree_ser16.sv
module tree_ser16
  import ser_pkg::*;
#(
  parameter int LEVELS      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [(1<<LEVELS)-1:0] par_word_i,
  input  logic                   high_first_i,
  input  logic [LEVELS-1:0]      div_clk_i,
  input  logic                   fwd_off_i,
  output logic                   ser_o,
  output logic                   fclk_o
);

  localparam int WIDTH = 1 << LEVELS;

  logic              rst_sync_n;
  logic [LEVELS-1:0] sel_w;
  logic              bound_w;
  logic [WIDTH-1:0]  word_w;
  logic              tree_bit_w;
  logic              ser_q;
  logic              ser_d;
  logic              fwd_en;

  ser_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  ser_phase_track #(.LEVELS(LEVELS)) u_phase (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .div_i   (div_clk_i),
    .sel_o   (sel_w),
    .bound_o (bound_w)
  );

  ser_word_cap #(.WIDTH(WIDTH)) u_cap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_i  (bound_w),
    .order_i (ser_order_e'(high_first_i)),
    .word_i  (par_word_i),
    .word_o  (word_w)
  );

  ser_mux_tree #(.LEVELS(LEVELS)) u_tree (
    .word_i (word_w),
    .sel_i  (sel_w),
    .bit_o  (tree_bit_w)
  );

  always_comb begin
    ser_d = tree_bit_w;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ser_q <= 1'b0;
    end else begin
      ser_q <= ser_d;
    end
  end

  assign ser_o  = ser_q;
  assign fwd_en = ~fwd_off_i;
  assign fclk_o = clk & fwd_en;

endmodule

// File: rtl/tree_ser16_chk.sv
module tree_ser16_chk #(
  parameter int LEVELS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [(1<<LEVELS)-1:0] word_i,
  input logic                   high_first_i,
  input logic [LEVELS-1:0]      div_i,
  input logic                   fwd_off_i,
  input logic                   ser_o,
  input logic                   fclk_o
);

  localparam int WIDTH = 1 << LEVELS;

  logic prev_top_q;
  logic seen_q;
  logic fall_w;

  assign fall_w = prev_top_q & ~div_i[LEVELS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_top_q <= 1'b0;
      seen_q     <= 1'b0;
    end else begin
      prev_top_q <= div_i[LEVELS-1];
      if (fall_w) begin
        seen_q <= 1'b1;
      end
    end
  end

  // R1: output stays low until a word has been captured
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (ser_o == 1'b0));

  // R3 with R6: low bit leaves first, two edges after capture
  a_r3_low_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_w && !high_first_i) |-> ##2 (ser_o == $past(word_i[0], 2)));

  // R4 with R6: high bit leaves first, two edges after capture
  a_r4_high_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_w && high_first_i) |-> ##2 (ser_o == $past(word_i[WIDTH-1], 2)));

  // R9: gated forwarded clock never pulses
  always_comb begin
    if (rst_n) begin
      a_r9_fwd_gated: assert (!(fwd_off_i && fclk_o));
    end
  end

endmodule

bind tree_ser16 tree_ser16_chk #(.LEVELS(LEVELS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .word_i       (par_word_i),
  .high_first_i (high_first_i),
  .div_i        (div_clk_i),
  .fwd_off_i    (fwd_off_i),
  .ser_o        (ser_o),
  .fclk_o       (fclk_o)
);

// File: tb/sim_tree_ser16.sv
module sim_tree_ser16;

  localparam int LV = 4;
  localparam int W  = 1 << LV;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  word = '1;
  logic          hf = 1'b0;
  logic [LV-1:0] cnt = '0;
  logic          off = 1'b0;
  logic          ser;
  logic          fclk;

  typedef struct {
    logic  b;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails = 0;
  int   words_driven = 0;
  bit   done = 1'b0;
  int   snap = 0;
  bit   armed = 1'b0;
  bit   started = 1'b0;

  tree_ser16 u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .par_word_i   (word),
    .high_first_i (hf),
    .div_clk_i    (cnt),
    .fwd_off_i    (off),
    .ser_o        (ser),
    .fclk_o       (fclk)
  );

  always #5 clk = ~clk;

  // External divider model: cnt[k] toggles at clk/2^(k+1).
  always @(negedge clk) cnt <= cnt + 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: present a word right after a capture edge; it is taken at the next one.
  task automatic drive_word(input logic [W-1:0] w, input logic ord, input bit disturb);
    do @(posedge clk); while (cnt != 0);
    #1;
    word = w;
    hf   = ord;
    for (int i = 0; i < W; i++) begin
      exp_t e;
      e.b   = ord ? w[W-1-i] : w[i];
      e.tag = disturb ? "R7 R8" : (ord ? "R4" : "R3");
      q.push_back(e);
    end
    words_driven++;
    if (disturb) begin
      repeat (4) @(posedge clk);
      #1;
      word = ~w;
      hf   = ~ord;
      repeat (5) @(posedge clk);
      #1;
      word = w;
      hf   = ord;
    end
  endtask

  // Monitor: one expected bit per cycle once the first driven word is out (R2 R5 R6).
  always @(posedge clk) begin : mon
    exp_t e;
    #2;
    if (rst_n) begin
      if (cnt == 0) begin
        if (snap > 0) armed = 1'b1;
        snap = words_driven;
      end
      if (cnt == 1 && armed) started = 1'b1;
      if (started && q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (ser !== e.b) begin
          fails++;
          $display("FAIL %s (R2 R5 R6) serial bit actual=%b expected=%b", e.tag, ser, e.b);
        end
      end
    end
  end

  initial begin : main
    bit seen0;
    logic [W-1:0] w;
    logic ord;
    seen0 = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(ser === 1'b0, "R1", "output during reset", W'(ser), '0);
    do begin @(negedge clk); #1; end while (cnt != 3);
    rst_n = 1'b1;
    // R1: zero until the first capture; then R6: bit 0 of 16'hFFFF one cycle later
    for (int k = 0; k < 40; k++) begin
      @(posedge clk);
      #2;
      if (cnt == 1 && seen0) begin
        check(ser === 1'b1, "R6", "first bit after first capture", W'(ser), 1);
        break;
      end
      check(ser === 1'b0, "R1", "output before first word", W'(ser), '0);
      if (cnt == 0) seen0 = 1'b1;
    end
    drive_word(16'h0001, 1'b0, 1'b0);
    drive_word(16'h0001, 1'b1, 1'b0);
    drive_word(16'h8000, 1'b0, 1'b0);
    drive_word(16'h8000, 1'b1, 1'b0);
    drive_word(16'hA5C3, 1'b0, 1'b1);
    drive_word(16'h3C5A, 1'b1, 1'b1);
    for (int i = 0; i < 30; i++) begin
      w   = W'($urandom);
      ord = 1'($urandom % 2);
      drive_word(w, ord, (i % 5) == 0);
    end
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    // R9: forwarded clock
    @(posedge clk); #2;
    check(fclk === 1'b1, "R9", "fclk high phase enabled", W'(fclk), 1);
    @(negedge clk); #2;
    check(fclk === 1'b0, "R9", "fclk low phase enabled", W'(fclk), 0);
    off = 1'b1;
    @(posedge clk); #2;
    check(fclk === 1'b0, "R9", "fclk high phase gated", W'(fclk), 0);
    @(negedge clk); #2;
    check(fclk === 1'b0, "R9", "fclk low phase gated", W'(fclk), 0);
    off = 1'b0;
    @(posedge clk); #2;
    check(fclk === 1'b1, "R9", "fclk re-enabled", W'(fclk), 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule